// File: doc/BRIEF.md
# In-Place Block Increment Engine

This engine is a small offload unit that takes a fixed block of 32 words in memory and adds a constant (100) to every word. The words are written back to the address they came from. Software reaches the engine through an AXI4-Lite control port. It writes a memory base address into one register and then writes a start bit into the control register. The engine then works as an AXI4 bus master. It fetches the whole block into a local buffer with one read burst, and then streams the incremented words back with one write burst to the same address.

Software watches the job through the control register, which shows whether the engine is idle, ready for a new job or busy. A done flag is raised once the memory has acknowledged the write-back, and it clears when the control register is read. A sticky error flag records any non-OKAY memory response during a job. Only one job runs at a time. A start request that arrives during a job is dropped. The base register may be rewritten at any time, but the engine samples it only at the moment a start is accepted.

The sequencer has six states:
- `S_IDLE` waits for an accepted start and captures the base address.
- `S_RD_REQ` presents the read address until the memory accepts it.
- `S_RD_BEAT` accepts 32 read beats into the buffer.
- `S_WR_REQ` presents the write address.
- `S_WR_BEAT` streams 32 incremented words.
- `S_WR_RESP` waits for the write response and then returns to `S_IDLE`.

The transitions are: start-accept, address-accepted (read), last-read-beat, address-accepted (write), last-write-beat and response-received.

Top module: `rmw_engine`

## Requirements
- R1: Each job issues exactly one read burst and one write burst. Both use length field 31, size code 2 (4 bytes per beat) and burst code 1 (INCR). The write burst carries 32 beats, has all byte strobes set, and asserts the last flag on the 32nd beat only.
- R2: The write address is not presented until all 32 read beats have been accepted.
- R3: Every written word equals the word read from the same position plus 100, modulo 2^32. Example: 0xFFFFFFF0 becomes 0x00000054, and 0x7FFFFFF0 becomes 0x80000054 with no saturation.
- R4: The write burst address equals the read burst address, which is the base register value captured when the job started.
- R5: The base address register sits at control offset 0x10, is 32 bits wide, and reads back what was last written.
- R6: Writing a 1 to bit 0 of the control register (offset 0x00) while idle starts a job. Writing 0 there starts nothing. Bit 0 always reads as 0.
- R7: In the control register, bit 2 (idle) and bit 3 (ready) read 1 when no job runs and 0 while a job runs.
- R8: Bit 1 (done) of the control register sets in the cycle the write response handshake completes. The first read of the control register after that returns 1, and the next read returns 0. A newly accepted start also clears done.
- R9: Bit 4 (error) of the control register is sticky. It sets on a non-OKAY read or write response, or on a read beat whose last flag disagrees with its position. The job still runs to completion, and the bit clears when the next job is accepted.
- R10: A start written during a job is ignored and causes no extra burst. A base write during a job does not change the running job, but the next started job uses it.
- R11: After reset, no master valid is asserted. The control register reads 0x0000000C and the base register reads 0.
- R12: On both ports, a valid that is raised with its payload stays raised, with the payload unchanged, until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | 5 | Control write address |
| s_awvalid | input | 1 | Control write address valid |
| s_awready | output | 1 | Control write address ready |
| s_wdata | input | 32 | Control write data |
| s_wstrb | input | 4 | Control write byte strobes |
| s_wvalid | input | 1 | Control write data valid |
| s_wready | output | 1 | Control write data ready |
| s_bresp | output | 2 | Control write response (always OKAY) |
| s_bvalid | output | 1 | Control write response valid |
| s_bready | input | 1 | Control write response ready |
| s_araddr | input | 5 | Control read address |
| s_arvalid | input | 1 | Control read address valid |
| s_arready | output | 1 | Control read address ready |
| s_rdata | output | 32 | Control read data |
| s_rresp | output | 2 | Control read response (always OKAY) |
| s_rvalid | output | 1 | Control read data valid |
| s_rready | input | 1 | Control read data ready |
| m_araddr | output | 32 | Memory read burst address |
| m_arlen | output | 8 | Memory read burst length field |
| m_arsize | output | 3 | Memory read beat size code |
| m_arburst | output | 2 | Memory read burst type |
| m_arvalid | output | 1 | Memory read address valid |
| m_arready | input | 1 | Memory read address ready |
| m_rdata | input | 32 | Memory read data |
| m_rresp | input | 2 | Memory read response |
| m_rlast | input | 1 | Memory read last beat |
| m_rvalid | input | 1 | Memory read data valid |
| m_rready | output | 1 | Memory read data ready |
| m_awaddr | output | 32 | Memory write burst address |
| m_awlen | output | 8 | Memory write burst length field |
| m_awsize | output | 3 | Memory write beat size code |
| m_awburst | output | 2 | Memory write burst type |
| m_awvalid | output | 1 | Memory write address valid |
| m_awready | input | 1 | Memory write address ready |
| m_wdata | output | 32 | Memory write data |
| m_wstrb | output | 4 | Memory write byte strobes |
| m_wlast | output | 1 | Memory write last beat |
| m_wvalid | output | 1 | Memory write data valid |
| m_wready | input | 1 | Memory write data ready |
| m_bresp | input | 2 | Memory write response |
| m_bvalid | input | 1 | Memory write response valid |
| m_bready | output | 1 | Memory write response ready |

## Verification
The bench drives words that cross 2^32 and the signed boundary. A design with a saturating or narrowed adder would write wrong values there. It stalls the memory's ready and valid so that a sequencer which advances its beat index without a handshake would shift or repeat words. It injects an error response on a single read beat and on the write response, then runs a clean job. This catches an error flag that is not sticky, one that never clears, and a job that aborts early. It also issues start and base writes in the middle of a job: a design that re-samples the base or accepts the start would show a second burst or a moved write-back address. Finally, it leaves done unread across a new start, which exposes a stale done flag.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_REQ,
        S_RD_BEAT,
        S_WR_REQ,
        S_WR_BEAT,
        S_WR_RESP
    } seq_state_t;

    localparam logic [1:0] BURST_INCR = 2'b01;
    localparam logic [1:0] RESP_OKAY  = 2'b00;

    // control register offsets (byte addresses)
    localparam int unsigned OFS_CTRL = 'h00;
    localparam int unsigned OFS_BASE = 'h10;

    // control register bit positions
    localparam int unsigned BIT_START = 0;
    localparam int unsigned BIT_DONE  = 1;
    localparam int unsigned BIT_IDLE  = 2;
    localparam int unsigned BIT_READY = 3;
    localparam int unsigned BIT_ERR   = 4;

endpackage

// File: rtl/rmw_csr.sv
module rmw_csr
    import rmw_pkg::*;
#(
    parameter int CSR_AW = 5,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CSR_AW-1:0]   s_awaddr,
    input  logic                s_awvalid,
    output logic                s_awready,
    input  logic [DATA_W-1:0]   s_wdata,
    input  logic [DATA_W/8-1:0] s_wstrb,
    input  logic                s_wvalid,
    output logic                s_wready,
    output logic [1:0]          s_bresp,
    output logic                s_bvalid,
    input  logic                s_bready,
    input  logic [CSR_AW-1:0]   s_araddr,
    input  logic                s_arvalid,
    output logic                s_arready,
    output logic [DATA_W-1:0]   s_rdata,
    output logic [1:0]          s_rresp,
    output logic                s_rvalid,
    input  logic                s_rready,
    input  logic                idle_i,
    input  logic                done_i,
    input  logic                err_i,
    output logic                start_o,
    output logic [ADDR_W-1:0]   base_o
);

    localparam int NBYTES = ADDR_W / 8;
    localparam logic [CSR_AW-1:0] A_CTRL = CSR_AW'(OFS_CTRL);
    localparam logic [CSR_AW-1:0] A_BASE = CSR_AW'(OFS_BASE);

    logic                bvalid_q;
    logic                rvalid_q;
    logic [DATA_W-1:0]   rdata_q;
    logic                done_q;
    logic                err_q;
    logic [ADDR_W-1:0]   base_q;
    logic                wr_hs;
    logic                rd_hs;
    logic                wr_base;
    logic [DATA_W-1:0]   status_word;

    // address and data are taken together, one write at a time
    assign wr_hs     = s_awvalid && s_wvalid && !bvalid_q;
    assign s_awready = wr_hs;
    assign s_wready  = wr_hs;
    assign s_bvalid  = bvalid_q;
    assign s_bresp   = RESP_OKAY;

    assign rd_hs     = s_arvalid && !rvalid_q;
    assign s_arready = !rvalid_q;
    assign s_rvalid  = rvalid_q;
    assign s_rdata   = rdata_q;
    assign s_rresp   = RESP_OKAY;

    assign start_o = wr_hs && (s_awaddr == A_CTRL) && s_wstrb[0]
                     && s_wdata[BIT_START] && idle_i;
    assign wr_base = wr_hs && (s_awaddr == A_BASE);
    assign base_o  = base_q;

    always_comb begin
        status_word            = '0;
        status_word[BIT_DONE]  = done_q;
        status_word[BIT_IDLE]  = idle_i;
        status_word[BIT_READY] = idle_i;
        status_word[BIT_ERR]   = err_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bvalid_q <= 1'b0;
        end else if (wr_hs) begin
            bvalid_q <= 1'b1;
        end else if (s_bready) begin
            bvalid_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else if (rd_hs) begin
            rvalid_q <= 1'b1;
            unique case (s_araddr)
                A_CTRL:  rdata_q <= status_word;
                A_BASE:  rdata_q <= DATA_W'(base_q);
                default: rdata_q <= '0;
            endcase
        end else if (s_rready) begin
            rvalid_q <= 1'b0;
        end
    end

    // done: set wins over a simultaneous read, start clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (start_o) begin
            done_q <= 1'b0;
        end else if (done_i) begin
            done_q <= 1'b1;
        end else if (rd_hs && (s_araddr == A_CTRL)) begin
            done_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (start_o) begin
            err_q <= 1'b0;
        end else if (err_i) begin
            err_q <= 1'b1;
        end
    end

    // per-byte strobed update of the base register
    for (genvar gb = 0; gb < NBYTES; gb++) begin : g_base_byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[gb*8 +: 8] <= 8'h00;
            end else if (wr_base && s_wstrb[gb]) begin
                base_q[gb*8 +: 8] <= s_wdata[gb*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/rmw_buf.sv
module rmw_buf #(
    parameter int WORDS    = 32,
    parameter int DATA_W   = 32,
    parameter int INCR_VAL = 100
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(WORDS)-1:0] wr_idx,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [$clog2(WORDS)-1:0] rd_idx,
    output logic [DATA_W-1:0]        rd_sum
);

    localparam logic [DATA_W-1:0] ADDEND = DATA_W'(INCR_VAL);

    logic [DATA_W-1:0] words [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            words[wr_idx] <= wr_data;
        end
    end

    // modular add on the way out; carry beyond DATA_W is dropped
    assign rd_sum = words[rd_idx] + ADDEND;

endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
    import rmw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WORDS  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [ADDR_W-1:0]        base_i,
    output logic                     idle_o,
    output logic                     done_o,
    output logic                     err_o,
    output logic [ADDR_W-1:0]        m_araddr,
    output logic [7:0]               m_arlen,
    output logic [2:0]               m_arsize,
    output logic [1:0]               m_arburst,
    output logic                     m_arvalid,
    input  logic                     m_arready,
    input  logic [DATA_W-1:0]        m_rdata,
    input  logic [1:0]               m_rresp,
    input  logic                     m_rlast,
    input  logic                     m_rvalid,
    output logic                     m_rready,
    output logic [ADDR_W-1:0]        m_awaddr,
    output logic [7:0]               m_awlen,
    output logic [2:0]               m_awsize,
    output logic [1:0]               m_awburst,
    output logic                     m_awvalid,
    input  logic                     m_awready,
    output logic [DATA_W-1:0]        m_wdata,
    output logic [DATA_W/8-1:0]      m_wstrb,
    output logic                     m_wlast,
    output logic                     m_wvalid,
    input  logic                     m_wready,
    input  logic [1:0]               m_bresp,
    input  logic                     m_bvalid,
    output logic                     m_bready,
    output logic                     buf_we_o,
    output logic [$clog2(WORDS)-1:0] buf_idx_o,
    output logic [DATA_W-1:0]        buf_wdata_o,
    input  logic [DATA_W-1:0]        buf_sum_i
);

    localparam int                  IDX_W     = $clog2(WORDS);
    localparam logic [IDX_W-1:0]    LAST_IDX  = IDX_W'(WORDS - 1);
    localparam logic [7:0]          LEN_FIELD = 8'(WORDS - 1);
    localparam logic [2:0]          SIZE_CODE = 3'($clog2(DATA_W / 8));

    seq_state_t        state_q;
    seq_state_t        state_d;
    logic [ADDR_W-1:0] job_addr_q;
    logic [IDX_W-1:0]  beat_q;
    logic              r_hs;
    logic              w_hs;
    logic              b_hs;
    logic              beat_last;

    assign r_hs      = (state_q == S_RD_BEAT) && m_rvalid;
    assign w_hs      = (state_q == S_WR_BEAT) && m_wready;
    assign b_hs      = (state_q == S_WR_RESP) && m_bvalid;
    assign beat_last = (beat_q == LAST_IDX);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start_i)                state_d = S_RD_REQ;
            S_RD_REQ:  if (m_arready)              state_d = S_RD_BEAT;
            S_RD_BEAT: if (r_hs && beat_last)      state_d = S_WR_REQ;
            S_WR_REQ:  if (m_awready)              state_d = S_WR_BEAT;
            S_WR_BEAT: if (w_hs && beat_last)      state_d = S_WR_RESP;
            S_WR_RESP: if (m_bvalid)               state_d = S_IDLE;
            default:                               state_d = S_IDLE;
        endcase
    end

    // job address and beat index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            job_addr_q <= '0;
            beat_q     <= '0;
        end else begin
            if ((state_q == S_IDLE) && start_i) begin
                job_addr_q <= base_i;
            end
            if ((state_q == S_RD_REQ) || (state_q == S_WR_REQ)) begin
                beat_q <= '0;
            end else if (r_hs || w_hs) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        m_arvalid   = 1'b0;
        m_rready    = 1'b0;
        m_awvalid   = 1'b0;
        m_wvalid    = 1'b0;
        m_bready    = 1'b0;
        idle_o      = 1'b0;
        done_o      = 1'b0;
        err_o       = 1'b0;
        buf_we_o    = 1'b0;
        unique case (state_q)
            S_IDLE:    idle_o    = 1'b1;
            S_RD_REQ:  m_arvalid = 1'b1;
            S_RD_BEAT: begin
                m_rready = 1'b1;
                buf_we_o = m_rvalid;
                err_o    = m_rvalid && ((m_rresp != RESP_OKAY) || (m_rlast != beat_last));
            end
            S_WR_REQ:  m_awvalid = 1'b1;
            S_WR_BEAT: m_wvalid  = 1'b1;
            S_WR_RESP: begin
                m_bready = 1'b1;
                done_o   = b_hs;
                err_o    = b_hs && (m_bresp != RESP_OKAY);
            end
            default:   idle_o    = 1'b0;
        endcase
    end

    assign buf_idx_o   = beat_q;
    assign buf_wdata_o = m_rdata;

    assign m_araddr  = job_addr_q;
    assign m_arlen   = LEN_FIELD;
    assign m_arsize  = SIZE_CODE;
    assign m_arburst = BURST_INCR;
    assign m_awaddr  = job_addr_q;
    assign m_awlen   = LEN_FIELD;
    assign m_awsize  = SIZE_CODE;
    assign m_awburst = BURST_INCR;
    assign m_wdata   = buf_sum_i;
    assign m_wstrb   = '1;
    assign m_wlast   = (state_q == S_WR_BEAT) && beat_last;

endmodule

// File: rtl/rmw_engine.sv
module rmw_engine #(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int WORDS    = 32,
    parameter int INCR_VAL = 100,
    parameter int CSR_AW   = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CSR_AW-1:0]   s_awaddr,
    input  logic                s_awvalid,
    output logic                s_awready,
    input  logic [DATA_W-1:0]   s_wdata,
    input  logic [DATA_W/8-1:0] s_wstrb,
    input  logic                s_wvalid,
    output logic                s_wready,
    output logic [1:0]          s_bresp,
    output logic                s_bvalid,
    input  logic                s_bready,
    input  logic [CSR_AW-1:0]   s_araddr,
    input  logic                s_arvalid,
    output logic                s_arready,
    output logic [DATA_W-1:0]   s_rdata,
    output logic [1:0]          s_rresp,
    output logic                s_rvalid,
    input  logic                s_rready,
    output logic [ADDR_W-1:0]   m_araddr,
    output logic [7:0]          m_arlen,
    output logic [2:0]          m_arsize,
    output logic [1:0]          m_arburst,
    output logic                m_arvalid,
    input  logic                m_arready,
    input  logic [DATA_W-1:0]   m_rdata,
    input  logic [1:0]          m_rresp,
    input  logic                m_rlast,
    input  logic                m_rvalid,
    output logic                m_rready,
    output logic [ADDR_W-1:0]   m_awaddr,
    output logic [7:0]          m_awlen,
    output logic [2:0]          m_awsize,
    output logic [1:0]          m_awburst,
    output logic                m_awvalid,
    input  logic                m_awready,
    output logic [DATA_W-1:0]   m_wdata,
    output logic [DATA_W/8-1:0] m_wstrb,
    output logic                m_wlast,
    output logic                m_wvalid,
    input  logic                m_wready,
    input  logic [1:0]          m_bresp,
    input  logic                m_bvalid,
    output logic                m_bready
);

    localparam int IDX_W = $clog2(WORDS);

    logic              job_start;
    logic [ADDR_W-1:0] base_addr;
    logic              eng_idle;
    logic              job_done;
    logic              job_err;
    logic              buf_we;
    logic [IDX_W-1:0]  buf_idx;
    logic [DATA_W-1:0] buf_wdata;
    logic [DATA_W-1:0] buf_sum;

    rmw_csr #(
        .CSR_AW (CSR_AW),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_awaddr  (s_awaddr),
        .s_awvalid (s_awvalid),
        .s_awready (s_awready),
        .s_wdata   (s_wdata),
        .s_wstrb   (s_wstrb),
        .s_wvalid  (s_wvalid),
        .s_wready  (s_wready),
        .s_bresp   (s_bresp),
        .s_bvalid  (s_bvalid),
        .s_bready  (s_bready),
        .s_araddr  (s_araddr),
        .s_arvalid (s_arvalid),
        .s_arready (s_arready),
        .s_rdata   (s_rdata),
        .s_rresp   (s_rresp),
        .s_rvalid  (s_rvalid),
        .s_rready  (s_rready),
        .idle_i    (eng_idle),
        .done_i    (job_done),
        .err_i     (job_err),
        .start_o   (job_start),
        .base_o    (base_addr)
    );

    rmw_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .WORDS  (WORDS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (job_start),
        .base_i      (base_addr),
        .idle_o      (eng_idle),
        .done_o      (job_done),
        .err_o       (job_err),
        .m_araddr    (m_araddr),
        .m_arlen     (m_arlen),
        .m_arsize    (m_arsize),
        .m_arburst   (m_arburst),
        .m_arvalid   (m_arvalid),
        .m_arready   (m_arready),
        .m_rdata     (m_rdata),
        .m_rresp     (m_rresp),
        .m_rlast     (m_rlast),
        .m_rvalid    (m_rvalid),
        .m_rready    (m_rready),
        .m_awaddr    (m_awaddr),
        .m_awlen     (m_awlen),
        .m_awsize    (m_awsize),
        .m_awburst   (m_awburst),
        .m_awvalid   (m_awvalid),
        .m_awready   (m_awready),
        .m_wdata     (m_wdata),
        .m_wstrb     (m_wstrb),
        .m_wlast     (m_wlast),
        .m_wvalid    (m_wvalid),
        .m_wready    (m_wready),
        .m_bresp     (m_bresp),
        .m_bvalid    (m_bvalid),
        .m_bready    (m_bready),
        .buf_we_o    (buf_we),
        .buf_idx_o   (buf_idx),
        .buf_wdata_o (buf_wdata),
        .buf_sum_i   (buf_sum)
    );

    rmw_buf #(
        .WORDS    (WORDS),
        .DATA_W   (DATA_W),
        .INCR_VAL (INCR_VAL)
    ) u_buf (
        .clk     (clk),
        .wr_en   (buf_we),
        .wr_idx  (buf_idx),
        .wr_data (buf_wdata),
        .rd_idx  (buf_idx),
        .rd_sum  (buf_sum)
    );

endmodule

// File: rtl/rmw_engine_chk.sv
module rmw_engine_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WORDS  = 32,
    parameter int CSR_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] m_araddr,
    input logic              m_arvalid,
    input logic              m_arready,
    input logic              m_rvalid,
    input logic              m_rready,
    input logic [ADDR_W-1:0] m_awaddr,
    input logic              m_awvalid,
    input logic              m_awready,
    input logic [DATA_W-1:0] m_wdata,
    input logic              m_wlast,
    input logic              m_wvalid,
    input logic              m_wready,
    input logic              m_bvalid,
    input logic              m_bready,
    input logic              s_bvalid,
    input logic              s_bready,
    input logic              s_rvalid,
    input logic              s_rready,
    input logic [CSR_AW-1:0] s_araddr,
    input logic              s_arvalid,
    input logic              s_arready,
    input logic              rd_done_bit
);

    localparam int CW = $clog2(WORDS) + 1;

    logic [CW-1:0]     rd_beats;
    logic [CW-1:0]     wr_beats;
    logic [ADDR_W-1:0] ar_base;
    logic              job_open;
    logic              resp_seen;
    logic              ctrl_rd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_beats  <= '0;
            wr_beats  <= '0;
            ar_base   <= '0;
            job_open  <= 1'b0;
            resp_seen <= 1'b0;
            ctrl_rd_q <= 1'b0;
        end else begin
            if (m_arvalid && m_arready) begin
                rd_beats  <= '0;
                wr_beats  <= '0;
                ar_base   <= m_araddr;
                job_open  <= 1'b1;
                resp_seen <= 1'b0;
            end else begin
                if (m_rvalid && m_rready) rd_beats <= rd_beats + 1'b1;
                if (m_wvalid && m_wready) wr_beats <= wr_beats + 1'b1;
                if (m_bvalid && m_bready) begin
                    job_open  <= 1'b0;
                    resp_seen <= 1'b1;
                end
            end
            if (s_arvalid && s_arready) begin
                ctrl_rd_q <= (s_araddr == '0);
            end
        end
    end

    p_ar_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_araddr)));

    p_aw_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr)));

    p_w_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata) && $stable(m_wlast)));

    p_lite_b_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && !s_bready) |=> s_bvalid);

    p_reads_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid |-> (rd_beats == CW'(WORDS)));

    p_in_place_r4: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid |-> (m_awaddr == ar_base));

    p_wlast_pos_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wvalid && m_wready) |-> (m_wlast == (wr_beats == CW'(WORDS - 1))));

    p_single_job_r10: assert property (@(posedge clk) disable iff (!rst_n)
        m_arvalid |-> !job_open);

    p_done_after_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && s_rready && ctrl_rd_q && rd_done_bit) |-> resp_seen);

endmodule

bind rmw_engine rmw_engine_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WORDS  (WORDS),
    .CSR_AW (CSR_AW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .m_araddr    (m_araddr),
    .m_arvalid   (m_arvalid),
    .m_arready   (m_arready),
    .m_rvalid    (m_rvalid),
    .m_rready    (m_rready),
    .m_awaddr    (m_awaddr),
    .m_awvalid   (m_awvalid),
    .m_awready   (m_awready),
    .m_wdata     (m_wdata),
    .m_wlast     (m_wlast),
    .m_wvalid    (m_wvalid),
    .m_wready    (m_wready),
    .m_bvalid    (m_bvalid),
    .m_bready    (m_bready),
    .s_bvalid    (s_bvalid),
    .s_bready    (s_bready),
    .s_rvalid    (s_rvalid),
    .s_rready    (s_rready),
    .s_araddr    (s_araddr),
    .s_arvalid   (s_arvalid),
    .s_arready   (s_arready),
    .rd_done_bit (s_rdata[1])
);

// File: tb/rmw_engine_tb_top.sv
module rmw_engine_tb_top;

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] seed;
        logic [31:0] step;
        logic        stall;
        logic        rerr;
        logic        werr;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        {32'h0000_0040, 32'h0000_0000, 32'h0000_0001, 1'b0, 1'b0, 1'b0},
        {32'h0000_0100, 32'hFFFF_FFE0, 32'h0000_0001, 1'b0, 1'b0, 1'b0},
        {32'h0000_0200, 32'h7FFF_FFF0, 32'h0000_0001, 1'b1, 1'b0, 1'b0},
        {32'h0000_0080, 32'hDEAD_BEEF, 32'h0101_0101, 1'b1, 1'b1, 1'b0},
        {32'h0000_0300, 32'h1234_5678, 32'h0000_0007, 1'b0, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  s_awaddr = '0;
    logic        s_awvalid = 1'b0;
    logic        s_awready;
    logic [31:0] s_wdata = '0;
    logic [3:0]  s_wstrb = '0;
    logic        s_wvalid = 1'b0;
    logic        s_wready;
    logic [1:0]  s_bresp;
    logic        s_bvalid;
    logic        s_bready = 1'b0;
    logic [4:0]  s_araddr = '0;
    logic        s_arvalid = 1'b0;
    logic        s_arready;
    logic [31:0] s_rdata;
    logic [1:0]  s_rresp;
    logic        s_rvalid;
    logic        s_rready = 1'b0;
    logic [31:0] m_araddr;
    logic [7:0]  m_arlen;
    logic [2:0]  m_arsize;
    logic [1:0]  m_arburst;
    logic        m_arvalid;
    logic        m_arready = 1'b0;
    logic [31:0] m_rdata = '0;
    logic [1:0]  m_rresp = '0;
    logic        m_rlast = 1'b0;
    logic        m_rvalid = 1'b0;
    logic        m_rready;
    logic [31:0] m_awaddr;
    logic [7:0]  m_awlen;
    logic [2:0]  m_awsize;
    logic [1:0]  m_awburst;
    logic        m_awvalid;
    logic        m_awready = 1'b0;
    logic [31:0] m_wdata;
    logic [3:0]  m_wstrb;
    logic        m_wlast;
    logic        m_wvalid;
    logic        m_wready = 1'b0;
    logic [1:0]  m_bresp = '0;
    logic        m_bvalid = 1'b0;
    logic        m_bready;

    always #10 clk = ~clk;

    rmw_engine dut_i (.*);

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // memory model state
    logic [31:0] mem [256];
    int          ar_count = 0;
    int          aw_count = 0;
    int          rd_beats_job = 0;
    int          wbeats = 0;
    int          wlast_bad = 0;
    int          strb_bad = 0;
    bit          early_aw = 1'b0;
    bit          stall_mode = 1'b0;
    bit          rerr_mode = 1'b0;
    bit          werr_mode = 1'b0;
    logic [31:0] last_araddr = '0;
    logic [31:0] last_awaddr = '0;
    logic [7:0]  last_arlen = '0;
    logic [7:0]  last_awlen = '0;
    logic [2:0]  last_arsize = '0;
    logic [2:0]  last_awsize = '0;
    logic [1:0]  last_arburst = '0;
    logic [1:0]  last_awburst = '0;

    function automatic int widx(input logic [31:0] a, input int i);
        return (int'(a[9:2]) + i) % 256;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic serve_read();
        int len;
        int ptr;
        @(negedge clk);
        m_arready = 1'b1;
        #1;
        while (!m_arvalid) begin @(negedge clk); #1; end
        last_araddr  = m_araddr;
        last_arlen   = m_arlen;
        last_arsize  = m_arsize;
        last_arburst = m_arburst;
        ar_count++;
        rd_beats_job = 0;
        len = int'(m_arlen);
        ptr = 0;
        @(posedge clk);
        @(negedge clk);
        m_arready = 1'b0;
        for (int b = 0; b <= len; b++) begin
            if (stall_mode && (b % 4 == 2)) begin
                m_rvalid = 1'b0;
                @(negedge clk);
            end
            m_rvalid = 1'b1;
            m_rdata  = mem[widx(last_araddr, b)];
            m_rresp  = (rerr_mode && b == 5) ? 2'b10 : 2'b00;
            m_rlast  = (b == len);
            #1;
            while (!m_rready) begin @(negedge clk); #1; end
            @(posedge clk);
            rd_beats_job++;
            @(negedge clk);
        end
        m_rvalid = 1'b0;
        m_rlast  = 1'b0;
        m_rresp  = 2'b00;
    endtask

    task automatic serve_write();
        int len;
        #1;
        m_awready = 1'b1;
        while (!m_awvalid) begin @(negedge clk); #1; end
        last_awaddr  = m_awaddr;
        last_awlen   = m_awlen;
        last_awsize  = m_awsize;
        last_awburst = m_awburst;
        aw_count++;
        wbeats    = 0;
        wlast_bad = 0;
        strb_bad  = 0;
        len = int'(m_awlen);
        @(posedge clk);
        @(negedge clk);
        m_awready = 1'b0;
        for (int b = 0; b <= len; b++) begin
            if (stall_mode && (b % 5 == 3)) begin
                m_wready = 1'b0;
                @(negedge clk);
            end
            m_wready = 1'b1;
            #1;
            while (!m_wvalid) begin @(negedge clk); #1; end
            mem[widx(last_awaddr, b)] = m_wdata;
            if (m_wlast != (b == len)) wlast_bad++;
            if (m_wstrb != 4'hF) strb_bad++;
            wbeats++;
            @(posedge clk);
            @(negedge clk);
            m_wready = 1'b0;
        end
        m_bvalid = 1'b1;
        m_bresp  = werr_mode ? 2'b10 : 2'b00;
        #1;
        while (!m_bready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        m_bvalid = 1'b0;
        m_bresp  = 2'b00;
    endtask

    initial begin
        wait (rst_n);
        forever begin
            serve_read();
            serve_write();
        end
    end

    // write address must not appear before the read block is complete
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (m_awvalid && rd_beats_job < 32) early_aw = 1'b1;
        end
    end

    task automatic lite_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        s_awaddr  = a;
        s_wdata   = d;
        s_wstrb   = 4'hF;
        s_awvalid = 1'b1;
        s_wvalid  = 1'b1;
        s_bready  = 1'b1;
        #1;
        while (!s_awready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        s_awvalid = 1'b0;
        s_wvalid  = 1'b0;
        #1;
        while (!s_bvalid) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        s_bready = 1'b0;
    endtask

    task automatic lite_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        s_araddr  = a;
        s_arvalid = 1'b1;
        s_rready  = 1'b1;
        #1;
        while (!s_arready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        s_arvalid = 1'b0;
        #1;
        while (!s_rvalid) begin @(negedge clk); #1; end
        d = s_rdata;
        @(posedge clk);
        @(negedge clk);
        s_rready = 1'b0;
    endtask

    task automatic poll_done(output logic [31:0] st);
        int n;
        n = 0;
        lite_read(5'h00, st);
        while (!st[1] && n < 2000) begin
            lite_read(5'h00, st);
            n++;
        end
    endtask

    task automatic fill(input logic [31:0] base, input logic [31:0] seed,
                        input logic [31:0] step);
        for (int i = 0; i < 32; i++) begin
            mem[widx(base, i)] = seed + step * 32'(i);
        end
    endtask

    function automatic int count_bad(input logic [31:0] base, input logic [31:0] seed,
                                     input logic [31:0] step);
        int bad;
        bad = 0;
        for (int i = 0; i < 32; i++) begin
            if (mem[widx(base, i)] != seed + step * 32'(i) + 32'd100) bad++;
        end
        return bad;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        logic [31:0] st;
        logic [31:0] rv;
        vec_t        cv;
        int          arc0;
        for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 + 32'(i);

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        #1;
        check(!m_arvalid && !m_awvalid && !m_wvalid, "R11", "master valids after reset",
              {29'd0, m_arvalid, m_awvalid, m_wvalid}, 32'd0);
        lite_read(5'h00, st);
        check(st == 32'h0000_000C, "R11", "control reset value", st, 32'h0000_000C);
        lite_read(5'h10, rv);
        check(rv == 32'h0, "R11", "base reset value", rv, 32'h0);

        // R5: base register read-back
        lite_write(5'h10, 32'hA5A5_A5A4);
        lite_read(5'h10, rv);
        check(rv == 32'hA5A5_A5A4, "R5", "base read-back", rv, 32'hA5A5_A5A4);

        // R6: writing 0 to start bit launches nothing
        arc0 = ar_count;
        lite_write(5'h00, 32'h0000_0000);
        repeat (20) @(posedge clk);
        check(ar_count == arc0, "R6", "no job on start=0",
              32'(ar_count), 32'(arc0));

        // vector table: one job per entry
        for (int v = 0; v < NV; v++) begin
            cv = VECS[v];
            stall_mode = cv.stall;
            rerr_mode  = cv.rerr;
            werr_mode  = cv.werr;
            early_aw   = 1'b0;
            arc0       = ar_count;
            fill(cv.base, cv.seed, cv.step);
            lite_write(5'h10, cv.base);
            lite_write(5'h00, 32'h1);
            poll_done(st);
            check(ar_count == arc0 + 1, "R1", "one read burst per job",
                  32'(ar_count), 32'(arc0 + 1));
            check(last_arlen == 8'd31 && last_arsize == 3'd2 && last_arburst == 2'b01,
                  "R1", "read burst fields",
                  {16'd0, last_arlen, 3'd0, last_arsize, last_arburst}, {16'd0, 8'd31, 3'd0, 3'd2, 2'b01});
            check(last_awlen == 8'd31 && last_awsize == 3'd2 && last_awburst == 2'b01,
                  "R1", "write burst fields",
                  {16'd0, last_awlen, 3'd0, last_awsize, last_awburst}, {16'd0, 8'd31, 3'd0, 3'd2, 2'b01});
            check(wbeats == 32 && wlast_bad == 0 && strb_bad == 0, "R1", "write beats/last/strobe",
                  32'(wbeats * 65536 + wlast_bad * 256 + strb_bad), 32'(32 * 65536));
            check(!early_aw, "R2", "write address before all reads", 32'(early_aw), 32'd0);
            check(count_bad(cv.base, cv.seed, cv.step) == 0, "R3", "incremented words",
                  32'(count_bad(cv.base, cv.seed, cv.step)), 32'd0);
            check(last_araddr == cv.base && last_awaddr == cv.base, "R4", "burst addresses",
                  last_awaddr, cv.base);
            check(st[3:0] == 4'b1110, "R7", "status idle/ready/done/start after job",
                  {28'd0, st[3:0]}, 32'hE);
            check(st[4] == (cv.rerr | cv.werr), "R9", "error bit after job",
                  {31'd0, st[4]}, {31'd0, cv.rerr | cv.werr});
            lite_read(5'h00, st);
            check(st[1] == 1'b0, "R8", "done cleared by prior read", {31'd0, st[1]}, 32'd0);
        end
        stall_mode = 1'b0;
        rerr_mode  = 1'b0;
        werr_mode  = 1'b0;

        // R8: done left unread, then cleared by a new start; R7 busy status
        fill(32'h0000_0180, 32'h0000_1000, 32'h3);
        lite_write(5'h10, 32'h0000_0180);
        lite_write(5'h00, 32'h1);
        repeat (300) @(posedge clk);
        fill(32'h0000_0180, 32'h0000_2000, 32'h5);
        arc0 = ar_count;
        lite_write(5'h00, 32'h1);
        lite_read(5'h00, st);
        check(st[4:0] == 5'b00000, "R7", "busy status (idle=0 ready=0 done=0 err=0)",
              {27'd0, st[4:0]}, 32'd0);
        // R10: start and base rewrite during the job
        lite_write(5'h00, 32'h1);
        lite_write(5'h10, 32'h0000_01C0);
        poll_done(st);
        check(ar_count == arc0 + 1, "R10", "start while busy ignored",
              32'(ar_count), 32'(arc0 + 1));
        check(last_awaddr == 32'h0000_0180, "R10", "running job keeps captured base",
              last_awaddr, 32'h0000_0180);
        check(count_bad(32'h0000_0180, 32'h0000_2000, 32'h5) == 0, "R3", "second job words",
              32'(count_bad(32'h0000_0180, 32'h0000_2000, 32'h5)), 32'd0);
        lite_read(5'h10, rv);
        check(rv == 32'h0000_01C0, "R5", "base rewritten during job", rv, 32'h0000_01C0);

        // R10: next start uses the new base
        fill(32'h0000_01C0, 32'hFFFF_FF9C, 32'h1);
        lite_write(5'h00, 32'h1);
        poll_done(st);
        check(last_araddr == 32'h0000_01C0 && last_awaddr == 32'h0000_01C0, "R10",
              "next job uses rewritten base", last_araddr, 32'h0000_01C0);
        check(mem[widx(32'h0000_01C0, 0)] == 32'h0000_0000, "R3", "wrap to zero",
              mem[widx(32'h0000_01C0, 0)], 32'h0000_0000);
        check(st[4] == 1'b0, "R9", "error cleared on clean job", {31'd0, st[4]}, 32'd0);

        repeat (10) @(posedge clk);
        finish_run();
    end

endmodule